// File: doc/BRIEF.md
# Shared Accumulating Shift Buffer

This block is one wide shift register used in turn by four serial datapath clients: an add-and-round unit, an add-and-pack unit, a byte-string-to-polynomial converter and a polynomial multiplier. A client reads a run of 64-bit memory words and appends each one to the buffer. Each word lands directly above the bits already held. The client then takes fixed-width fields off the low end, one field per request, and works on each field serially. The window is sized for the widest client, the multiplier, at 676 bits. The narrower clients use only the bottom 320 or 64 bits of it.

The clients never run at the same time, so there is no arbitration. Ownership follows a client-select input. When the select value changes, the window and the fill count are wiped, so no data passes from one client to the next. A load that does not fit is refused and flagged. A shift that asks for more bits than are held, or for a width outside 1..64, is refused and flagged. In both cases the buffer is left untouched. When a load and a shift arrive in the same cycle, the shift is applied first and the word is appended at the reduced fill level.

Top module: `shared_shift_buffer`

## Requirements
- R1: After synchronous reset, `win_low` and `fill_level` are zero, both flags are low, and client 0 owns the buffer.
- R2: An accepted load places the 64-bit word at bit positions fill_level to fill_level+63 of the window. `win_low` always shows window bits 63:0, one cycle after the request.
- R3: Each accepted load raises `fill_level` by exactly 64 in the following cycle.
- R4: An accepted shift of w bits, 1 <= w <= 64, discards the w lowest window bits, moves the rest down by w, and lowers `fill_level` by w.
- R5: The capacity is 676 bits. A load is refused when fewer than 64 bits would be free after any same-cycle shift. `load_overflow` is then high for one cycle and the window does not take the word.
- R6: A shift whose width is 0, above 64 or above the current fill level is refused. `shift_underflow` is then high for one cycle and the window and fill level are unchanged.
- R7: A cycle in which `client_sel` differs from the current owner makes that value the owner. It clears the window and the fill level and ignores any load or shift requested in the same cycle.
- R8: When a load and a shift are requested together, the shift is applied first and the word is appended at the fill level left after the shift.
- R9: Each flag reflects only the requests of the previous cycle, and is low after a cycle with no failed request.
- R10: Window bits at or above the fill level always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| client_sel | input | 2 | Client that owns the buffer |
| load_valid | input | 1 | Append `load_word` this cycle |
| load_word | input | 64 | Memory word to append |
| shift_req | input | 1 | Remove `shift_width` bits from the low end |
| shift_width | input | 7 | Number of bits to remove, 1..64 is legal |
| win_low | output | 64 | Window bits 63:0 |
| fill_level | output | 10 | Number of valid bits held |
| load_overflow | output | 1 | Previous cycle's load was refused |
| shift_underflow | output | 1 | Previous cycle's shift was refused |

## Verification
The properties assume that `client_sel` changes only on an intended hand-over, and that `shift_width` matters only while `shift_req` is high. The single-request properties apply only when the other request line is low, so the stimulus produces combined load-and-shift cycles only in explicit cases whose results are worked out separately. Words are distinct computed patterns, so a misplaced append or a wrong shift distance shows up in `win_low`. The bench fills the window to exactly the point where the next load no longer fits, and it tries both a shift that frees too little room and one that frees enough.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  localparam int unsigned SSB_BUF_W   = 676;
  localparam int unsigned SSB_WORD_W  = 64;
  localparam int unsigned SSB_CLIENTS = 4;

  typedef struct packed {
    logic ovf;
    logic unf;
  } ssb_flags_t;
endpackage

// File: rtl/ssb_owner_guard.sv
module ssb_owner_guard #(
  parameter int unsigned CLIENTS = 4,
  localparam int unsigned SEL_W  = (CLIENTS > 1) ? $clog2(CLIENTS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] client_sel,
  output logic             clr,
  output logic [SEL_W-1:0] owner
);
  logic [SEL_W-1:0] owner_q;

  assign clr   = (client_sel != owner_q);
  assign owner = owner_q;

  always_ff @(posedge clk) begin
    if (rst) owner_q <= '0;
    else     owner_q <= client_sel;
  end

  p_owner_track_r7: assert property (@(posedge clk) disable iff (rst)
    clr |=> (owner_q == $past(client_sel)));
endmodule

// File: rtl/ssb_fill_ctrl.sv
module ssb_fill_ctrl
  import ssb_pkg::*;
#(
  parameter int unsigned BUF_W  = 676,
  parameter int unsigned WORD_W = 64,
  localparam int unsigned CNT_W = $clog2(BUF_W + 1),
  localparam int unsigned SHW_W = $clog2(WORD_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load_valid,
  input  logic             shift_req,
  input  logic [SHW_W-1:0] shift_width,
  output logic             do_shift,
  output logic             do_load,
  output logic [CNT_W-1:0] base,
  output logic [CNT_W-1:0] fill_q,
  output ssb_flags_t       flags_q
);
  localparam logic [CNT_W-1:0] LOAD_LIMIT = CNT_W'(BUF_W - WORD_W);
  localparam logic [CNT_W-1:0] WORD_CNT   = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CAP_CNT    = CNT_W'(BUF_W);

  logic [CNT_W-1:0] width_c;
  logic             shift_ok;
  logic             load_ok;
  logic [CNT_W-1:0] fill_mid;

  always_comb begin
    width_c  = CNT_W'(shift_width);
    shift_ok = shift_req && (shift_width != '0) &&
               (shift_width <= SHW_W'(WORD_W)) && (width_c <= fill_q);
    fill_mid = shift_ok ? (fill_q - width_c) : fill_q;
    load_ok  = load_valid && (fill_mid <= LOAD_LIMIT);
  end

  assign do_shift = !clr && shift_ok;
  assign do_load  = !clr && load_ok;
  assign base     = fill_mid;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      fill_q  <= '0;
      flags_q <= '0;
    end else begin
      fill_q      <= load_ok ? (fill_mid + WORD_CNT) : fill_mid;
      flags_q.ovf <= load_valid && !load_ok;
      flags_q.unf <= shift_req && !shift_ok;
    end
  end

  p_fill_cap_r5: assert property (@(posedge clk) disable iff (rst)
    fill_q <= CAP_CNT);

  p_load_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!clr && load_valid && !shift_req && fill_q <= LOAD_LIMIT)
    |=> (fill_q == $past(fill_q) + WORD_CNT) && !flags_q.ovf);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    (!clr && load_valid && !shift_req && fill_q > LOAD_LIMIT)
    |=> flags_q.ovf && (fill_q == $past(fill_q)));

  p_underflow_r6: assert property (@(posedge clk) disable iff (rst)
    (!clr && shift_req && !load_valid && CNT_W'(shift_width) > fill_q)
    |=> flags_q.unf && (fill_q == $past(fill_q)));

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    clr |=> (fill_q == '0) && !flags_q.ovf && !flags_q.unf);

  p_flags_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (!load_valid && !shift_req) |=> !flags_q.ovf && !flags_q.unf);
endmodule

// File: rtl/ssb_window.sv
module ssb_window #(
  parameter int unsigned BUF_W  = 676,
  parameter int unsigned WORD_W = 64,
  parameter int unsigned PEEK_W = 64,
  localparam int unsigned CNT_W = $clog2(BUF_W + 1),
  localparam int unsigned SHW_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              do_shift,
  input  logic [SHW_W-1:0]  shift_width,
  input  logic              do_load,
  input  logic [CNT_W-1:0]  base,
  input  logic [WORD_W-1:0] load_word,
  input  logic [CNT_W-1:0]  fill_i,
  output logic [PEEK_W-1:0] peek
);
  logic [BUF_W-1:0] win_q;
  logic [BUF_W-1:0] after_sh;
  logic [BUF_W-1:0] placed;
  logic [BUF_W-1:0] win_d;

  always_comb begin
    after_sh = do_shift ? (win_q >> shift_width) : win_q;
    placed   = {{(BUF_W - WORD_W){1'b0}}, load_word} << base;
    win_d    = do_load ? (after_sh | placed) : after_sh;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) win_q <= '0;
    else            win_q <= win_d;
  end

  generate
    if (PEEK_W <= BUF_W) begin : g_peek_direct
      assign peek = win_q[PEEK_W-1:0];
    end else begin : g_peek_pad
      assign peek = {{(PEEK_W - BUF_W){1'b0}}, win_q};
    end
  endgenerate

  p_upper_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (win_q >> fill_i) == '0);

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!clr && !do_shift && !do_load) |=> $stable(win_q));
endmodule

// File: rtl/shared_shift_buffer.sv
module shared_shift_buffer
  import ssb_pkg::*;
#(
  parameter int unsigned BUF_W   = SSB_BUF_W,
  parameter int unsigned WORD_W  = SSB_WORD_W,
  parameter int unsigned CLIENTS = SSB_CLIENTS,
  localparam int unsigned SEL_W  = (CLIENTS > 1) ? $clog2(CLIENTS) : 1,
  localparam int unsigned CNT_W  = $clog2(BUF_W + 1),
  localparam int unsigned SHW_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  client_sel,
  input  logic              load_valid,
  input  logic [WORD_W-1:0] load_word,
  input  logic              shift_req,
  input  logic [SHW_W-1:0]  shift_width,
  output logic [WORD_W-1:0] win_low,
  output logic [CNT_W-1:0]  fill_level,
  output logic              load_overflow,
  output logic              shift_underflow
);
  logic             clr;
  logic [SEL_W-1:0] owner;
  logic             do_shift;
  logic             do_load;
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] fill_q;
  ssb_flags_t       flags_q;

  ssb_owner_guard #(.CLIENTS(CLIENTS)) u_guard (
    .clk(clk), .rst(rst), .client_sel(client_sel), .clr(clr), .owner(owner)
  );

  ssb_fill_ctrl #(.BUF_W(BUF_W), .WORD_W(WORD_W)) u_fill (
    .clk(clk), .rst(rst), .clr(clr), .load_valid(load_valid),
    .shift_req(shift_req), .shift_width(shift_width), .do_shift(do_shift),
    .do_load(do_load), .base(base), .fill_q(fill_q), .flags_q(flags_q)
  );

  ssb_window #(.BUF_W(BUF_W), .WORD_W(WORD_W), .PEEK_W(WORD_W)) u_win (
    .clk(clk), .rst(rst), .clr(clr), .do_shift(do_shift),
    .shift_width(shift_width), .do_load(do_load), .base(base),
    .load_word(load_word), .fill_i(fill_q), .peek(win_low)
  );

  assign fill_level      = fill_q;
  assign load_overflow   = flags_q.ovf;
  assign shift_underflow = flags_q.unf;

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (fill_level == '0) && (win_low == '0) && (owner == '0)
            && !load_overflow && !shift_underflow);
endmodule

// File: tb/test_shared_shift_buffer.sv
module test_shared_shift_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int BUF_W  = 676;
  localparam int WORD_W = 64;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  client_sel;
  logic        load_valid;
  logic [63:0] load_word;
  logic        shift_req;
  logic [6:0]  shift_width;
  logic [63:0] win_low;
  logic [9:0]  fill_level;
  logic        load_overflow;
  logic        shift_underflow;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [63:0] peek;
    int          fill;
    bit          ovf;
    bit          unf;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  logic [BUF_W-1:0] m_buf;
  int               m_fill;
  logic [1:0]       m_owner;

  shared_shift_buffer i_shared_shift_buffer (
    .clk(clk), .rst(rst), .client_sel(client_sel), .load_valid(load_valid),
    .load_word(load_word), .shift_req(shift_req), .shift_width(shift_width),
    .win_low(win_low), .fill_level(fill_level), .load_overflow(load_overflow),
    .shift_underflow(shift_underflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] pat(int k);
    return {32'hC3A5_0F1E ^ (32'(k) * 32'h9E37_79B9), 32'h1234_5678 + 32'(k) * 32'h0101_0101};
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Driver: applies one cycle of stimulus and queues the result the requirements predict
  task automatic drive(input logic [1:0] sel, input bit ld, input logic [63:0] data,
                       input bit sh, input int w, input string tag);
    exp_t e;
    @(negedge clk);
    client_sel  = sel;
    load_valid  = ld;
    load_word   = data;
    shift_req   = sh;
    shift_width = 7'(w);
    e.ovf = 0;
    e.unf = 0;
    if (sel != m_owner) begin
      m_owner = sel;
      m_buf   = '0;
      m_fill  = 0;
    end else begin
      e.unf = sh && !(w >= 1 && w <= WORD_W && w <= m_fill);
      if (sh && !e.unf) begin
        m_buf  = m_buf >> w;
        m_fill = m_fill - w;
      end
      e.ovf = ld && (BUF_W - m_fill < WORD_W);
      if (ld && !e.ovf) begin
        m_buf  = m_buf | ({{(BUF_W-WORD_W){1'b0}}, data} << m_fill);
        m_fill = m_fill + WORD_W;
      end
    end
    e.peek = m_buf[63:0];
    e.fill = m_fill;
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input string tag);
    drive(m_owner, 0, '0, 0, 0, tag);
  endtask

  // Monitor: compares each registered result just after the edge that produced it
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (win_low !== e.peek || int'(fill_level) != e.fill ||
            load_overflow !== e.ovf || shift_underflow !== e.unf) begin
          errors++;
          $display("FAIL %s: actual win=%h fill=%0d ovf=%b unf=%b expected win=%h fill=%0d ovf=%b unf=%b",
                   e.tag, win_low, fill_level, load_overflow, shift_underflow,
                   e.peek, e.fill, e.ovf, e.unf);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL R1: watchdog expired, actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    client_sel = '0; load_valid = 0; load_word = '0; shift_req = 0; shift_width = '0;
    m_buf = '0; m_fill = 0; m_owner = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    checks++;
    if (win_low !== '0 || fill_level !== '0 || load_overflow !== 1'b0 || shift_underflow !== 1'b0) begin
      errors++;
      $display("FAIL R1: actual win=%h fill=%0d ovf=%b unf=%b expected all zero",
               win_low, fill_level, load_overflow, shift_underflow);
    end

    drive(0, 1, pat(0), 0, 0, "R2");
    drive(0, 1, pat(1), 0, 0, "R3");
    drive(0, 0, '0, 1, 8, "R4");
    drive(0, 0, '0, 1, 64, "R4");
    drive(0, 0, '0, 1, 57, "R6");        // 57 > fill of 56
    idle("R9");
    drive(0, 0, '0, 1, 0, "R6");         // zero width
    drive(0, 0, '0, 1, 65, "R6");        // width above 64
    drive(0, 0, '0, 1, 56, "R4");        // drain to empty
    drive(0, 0, '0, 1, 1, "R6");         // shift from empty
    drive(0, 1, pat(2), 0, 0, "R2");
    drive(0, 1, pat(3), 1, 20, "R8");    // shift then append at 44
    drive(0, 0, '0, 1, 50, "R10");       // fill 58, upper bits zero
    for (int k = 0; k < 9; k++) drive(0, 1, pat(10 + k), 0, 0, "R3");
    drive(0, 1, pat(30), 0, 0, "R5");    // 634 held, 42 free
    idle("R9");
    drive(0, 1, pat(31), 1, 10, "R5");   // 624 after shift, still no room
    drive(0, 1, pat(32), 1, 30, "R8");   // 604 after shift, word fits
    drive(2, 1, pat(40), 1, 8, "R7");    // hand-over wipes and ignores requests
    drive(2, 1, pat(41), 0, 0, "R7");
    drive(0, 0, '0, 0, 0, "R7");
    drive(0, 1, pat(42), 1, 4, "R6");    // shift refused, load still accepted
    drive(0, 0, '0, 1, 33, "R10");
    idle("R9");

    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule